// File: doc/BRIEF.md
# Programmable-Propagate Adder ALU

This block is an integer ALU that runs every operation through a single carry network. Each bit slice builds a propagate term and a generate term from its operand pair. The propagate term comes from a 4-entry truth table that all slices share, so it can be any two-input Boolean function. The generate term is chosen from A AND B, A AND NOT B, or constant zero. Each sum bit is the propagate term XOR the carry that enters that slice.

A small decoder turns a 3-bit opcode into three things: the truth table, the generate choice and the forced carry-in. Addition programs XOR with an AND generate. Subtraction programs XNOR with an A AND NOT B generate and a carry-in of one. No separate operand inverter is needed. Logic operations program their own truth table and force both generate and carry-in to zero, so every carry is zero and the sum equals the propagate term.

The result and carry-out are captured in a register on each rising clock edge. The data output shows the register only while the output enable is high. The carry network is a parameter-selected variant: a serial ripple chain or a logarithmic prefix tree.

Top module: `alu_pg_top`

## Requirements
- R1: Opcode 000 (add) gives result = (A + B) mod 2^WIDTH, with carry-out equal to bit WIDTH of the full sum.
- R2: Opcode 001 (subtract) gives result = (A - B) mod 2^WIDTH. Carry-out is 1 when A >= B (no borrow) and 0 when A < B.
- R3: Opcode 010 gives the bitwise AND of A and B (truth table {A,B} index 3 only set).
- R4: Opcode 011 gives the bitwise OR of A and B (truth table indices 1, 2 and 3 set).
- R5: Opcode 100 gives the bitwise XOR of A and B (truth table indices 1 and 2 set).
- R6: Opcode 101 passes A unchanged (truth table indices 2 and 3 set).
- R7: Opcodes 110 and 111 give an all-zero result and a carry-out of 0.
- R8: Carry-out is 0 for every logic opcode (010 through 111), whatever the operands are.
- R9: While the output enable is low, the data output reads all zeros. The register still captures, and raising the enable between edges shows the captured value without a clock edge.
- R10: While reset is asserted (active low), the result register and carry-out are zero.
- R11: Outputs reflect the opcode and operands present at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| oe_i | input | 1 | Output enable for the data output |
| res_o | output | WIDTH | Registered result, zero while oe_i is low |
| cout_o | output | 1 | Registered carry-out |

## Verification
On every cycle, the assertions compare the registered result of add, subtract, AND, OR and XOR against arithmetic on the operands from the previous cycle. They also check that the carry-out stays low after any logic opcode, and that unused opcodes clear the register. Some behaviour only the bench scenarios can show. This covers output-enable gating together with the captured value becoming visible mid-cycle, the reset state, borrow cases with A < B at the operand extremes, and pass-through of A.

// File: rtl/alu_pg_pkg.sv
package alu_pg_pkg;
   localparam logic [2:0] OP_ADD   = 3'b000;
   localparam logic [2:0] OP_SUB   = 3'b001;
   localparam logic [2:0] OP_AND   = 3'b010;
   localparam logic [2:0] OP_OR    = 3'b011;
   localparam logic [2:0] OP_XOR   = 3'b100;
   localparam logic [2:0] OP_PASSA = 3'b101;

   // truth tables, bit index = {a,b}
   localparam logic [3:0] TT_ZERO = 4'b0000;
   localparam logic [3:0] TT_AND  = 4'b1000;
   localparam logic [3:0] TT_OR   = 4'b1110;
   localparam logic [3:0] TT_XOR  = 4'b0110;
   localparam logic [3:0] TT_XNOR = 4'b1001;
   localparam logic [3:0] TT_PASA = 4'b1100;

   typedef enum logic [1:0] {
      GEN_ZERO = 2'd0,
      GEN_AND  = 2'd1,
      GEN_ANDN = 2'd2
   } gen_sel_e;

   typedef struct packed {
      logic [3:0] ptab;
      gen_sel_e   gsel;
      logic       cin;
      logic       arith;
   } alu_ctl_t;
endpackage

// File: rtl/alu_pg_decode.sv
module alu_pg_decode
   import alu_pg_pkg::*;
(
   input  logic [2:0] op_i,
   output alu_ctl_t   ctl_o
);
   always_comb begin
      ctl_o = '{ptab: TT_ZERO, gsel: GEN_ZERO, cin: 1'b0, arith: 1'b0};
      case (op_i)
         OP_ADD:   ctl_o = '{ptab: TT_XOR,  gsel: GEN_AND,  cin: 1'b0, arith: 1'b1};
         OP_SUB:   ctl_o = '{ptab: TT_XNOR, gsel: GEN_ANDN, cin: 1'b1, arith: 1'b1};
         OP_AND:   ctl_o.ptab = TT_AND;
         OP_OR:    ctl_o.ptab = TT_OR;
         OP_XOR:   ctl_o.ptab = TT_XOR;
         OP_PASSA: ctl_o.ptab = TT_PASA;
         default:  ctl_o.ptab = TT_ZERO;
      endcase
   end

   // R8
   always_comb begin
      logic_ops_chk: assert (!(op_i inside {OP_AND, OP_OR, OP_XOR, OP_PASSA, 3'b110, 3'b111})
                              || (ctl_o.gsel == GEN_ZERO && !ctl_o.cin));
   end
endmodule

// File: rtl/alu_pg_slices.sv
module alu_pg_slices
   import alu_pg_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       ptab_i,
   input  gen_sel_e         gsel_i,
   output logic [WIDTH-1:0] p_o,
   output logic [WIDTH-1:0] g_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign p_o[i] = ptab_i[{a_i[i], b_i[i]}];
      always_comb begin
         unique case (gsel_i)
            GEN_AND:  g_o[i] = a_i[i] & b_i[i];
            GEN_ANDN: g_o[i] = a_i[i] & ~b_i[i];
            default:  g_o[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/alu_pg_carry.sv
module alu_pg_carry #(
   parameter int WIDTH       = 16,
   parameter int CHAIN_STYLE = 1    // 0: ripple, 1: prefix tree
) (
   input  logic [WIDTH-1:0] p_i,
   input  logic [WIDTH-1:0] g_i,
   input  logic             cin_i,
   output logic [WIDTH:0]   c_o     // c_o[k] = carry into slice k, c_o[WIDTH] = carry-out
);
   localparam int N  = WIDTH + 1;
   localparam int LV = $clog2(N);

   if (CHAIN_STYLE != 0 && CHAIN_STYLE != 1) begin : g_bad_style
      $error("alu_pg_carry: CHAIN_STYLE must be 0 or 1");
   end

   if (CHAIN_STYLE == 0) begin : g_ripple
      assign c_o[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign c_o[i+1] = g_i[i] | (p_i[i] & c_o[i]);
      end
   end else begin : g_tree
      // position 0 carries the carry-in as a generate with no propagate
      logic [LV:0][N-1:0] gg;
      logic [LV:0][N-1:0] pp;
      assign gg[0] = {g_i, cin_i};
      assign pp[0] = {p_i, 1'b0};
      for (genvar l = 0; l < LV; l++) begin : g_lvl
         localparam int D = 1 << l;
         for (genvar j = 0; j < N; j++) begin : g_node
            if (j >= D) begin : g_comb
               assign gg[l+1][j] = gg[l][j] | (pp[l][j] & gg[l][j-D]);
               assign pp[l+1][j] = pp[l][j] & pp[l][j-D];
            end else begin : g_pass
               assign gg[l+1][j] = gg[l][j];
               assign pp[l+1][j] = pp[l][j];
            end
         end
      end
      assign c_o = gg[LV];
   end
endmodule

// File: rtl/alu_pg_top.sv
module alu_pg_top
   import alu_pg_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int CHAIN_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             oe_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("alu_pg_top: WIDTH must be at least 2");
   end

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] p, g, sum;
   logic [WIDTH:0]   c;
   logic [WIDTH-1:0] res_q;
   logic             cout_q;

   alu_pg_decode u_dec (.op_i(op_i), .ctl_o(ctl));

   alu_pg_slices #(.WIDTH(WIDTH)) u_sl (
      .a_i(a_i), .b_i(b_i), .ptab_i(ctl.ptab), .gsel_i(ctl.gsel),
      .p_o(p), .g_o(g));

   alu_pg_carry #(.WIDTH(WIDTH), .CHAIN_STYLE(CHAIN_STYLE)) u_cy (
      .p_i(p), .g_i(g), .cin_i(ctl.cin), .c_o(c));

   assign sum = p ^ c[WIDTH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         cout_q <= 1'b0;
      end else begin
         res_q  <= sum;
         cout_q <= ctl.arith & c[WIDTH];
      end
   end

   assign res_o  = oe_i ? res_q : '0;
   assign cout_o = cout_q;

   // R1
   add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_ADD) |=> ({cout_q, res_q} == $past({1'b0, a_i} + {1'b0, b_i})));
   // R2
   sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SUB) |=> (res_q == $past(a_i - b_i)) && (cout_q == $past(a_i >= b_i)));
   // R3
   and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_AND) |=> (res_q == $past(a_i & b_i)));
   // R4
   or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_OR) |=> (res_q == $past(a_i | b_i)));
   // R5
   xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_XOR) |=> (res_q == $past(a_i ^ b_i)));
   // R7
   unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[2:1] == 2'b11) |=> (res_q == '0) && !cout_q);
   // R8
   logic_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[2:1] != 2'b00) |=> !cout_q);
endmodule

// File: tb/tb_alu_pg_top.sv
module tb_alu_pg_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   op = '0;
   logic [W-1:0] a = '0, b = '0;
   logic         oe = 1'b1;
   logic [W-1:0] res;
   logic         cout;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   alu_pg_top #(.WIDTH(W), .CHAIN_STYLE(1)) dut (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
      .oe_i(oe), .res_o(res), .cout_o(cout));

   function automatic logic [W:0] ref_model(input logic [2:0] o,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] y);
      case (o)
         3'b000: return {1'b0, x} + {1'b0, y};
         3'b001: return {(x >= y), x - y};
         3'b010: return {1'b0, x & y};
         3'b011: return {1'b0, x | y};
         3'b100: return {1'b0, x ^ y};
         3'b101: return {1'b0, x};
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] o);
      case (o)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b011: return "R4";
         3'b100: return "R5";
         3'b101: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, capture at the rising edge, check at the next falling edge (R11)
   task automatic run_op(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W:0] e;
      op = o; a = x; b = y; oe = 1'b1;
      e = ref_model(o, x, y);
      @(negedge clk);
      check(req_of(o), {cout, res}, e);
      if (o[2:1] != 2'b00) check("R8", {W'(0), cout}, '0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R10: reset state
      @(negedge clk);
      op = 3'b000; a = 16'hFFFF; b = 16'h0001;
      @(negedge clk);
      check("R10", {cout, res}, '0);
      rst_n = 1'b1;

      // directed corners
      run_op(3'b000, 16'hFFFF, 16'h0001);   // R1 wrap with carry
      run_op(3'b000, 16'h7FFF, 16'h0001);   // R1
      run_op(3'b001, 16'h0000, 16'h0001);   // R2 borrow, A < B
      run_op(3'b001, 16'h1234, 16'h1234);   // R2 equal, no borrow
      run_op(3'b001, 16'h0005, 16'hFFFF);   // R2 borrow
      run_op(3'b010, 16'hF0F0, 16'hFF00);   // R3
      run_op(3'b011, 16'hF0F0, 16'h0F0F);   // R4
      run_op(3'b100, 16'hFFFF, 16'hFFFF);   // R5
      run_op(3'b101, 16'hA5C3, 16'hFFFF);   // R6
      run_op(3'b110, 16'hFFFF, 16'hFFFF);   // R7
      run_op(3'b111, 16'hFFFF, 16'h0001);   // R7

      // R11: latency - back-to-back ops, each visible exactly one cycle later
      op = 3'b000; a = 16'h0010; b = 16'h0020;
      @(negedge clk);
      op = 3'b010; a = 16'h00FF; b = 16'h0F0F;
      #1 check("R11", {cout, res}, 17'h00030);
      @(negedge clk);
      check("R11", {cout, res}, 17'h0000F);

      // R9: output enable gating
      op = 3'b100; a = 16'h1357; b = 16'h2468; oe = 1'b0;
      @(negedge clk);
      check("R9", {1'b0, res}, '0);
      #1 oe = 1'b1;
      #1 check("R9", {1'b0, res}, {1'b0, 16'h1357 ^ 16'h2468});

      // constrained random over all opcodes, biased toward borrow cases
      for (int i = 0; i < 600; i++) begin
         logic [2:0]   ro;
         logic [W-1:0] ra, rb;
         ro = 3'($urandom_range(0, 7));
         ra = W'($urandom);
         rb = W'($urandom);
         if (ro == 3'b001 && i % 3 == 0 && ra > rb) begin
            logic [W-1:0] t;
            t = ra; ra = rb; rb = t;
         end
         run_op(ro, ra, rb);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule